// File: doc/BRIEF.md
# Multi-Area Horizontal Clock Generator

This block drives the two complementary horizontal shift clocks of an image sensor, `h1` and `h2`, across one line of pixels. Outside a programmable blanking window both outputs run free at half the pixel rate. Inside the window the span is cut into equal slots. Each slot maps to one of six pulse templates (areas). Each area places up to three bursts of two-cycle pulses at offsets that all areas share, and each area keeps its own pulse count for every burst and for each of the two outputs.

A pulse count of zero removes that burst. Bursts never run past the end of their slot. On odd lines a small order table can remap slots onto areas, so the same templates play back in a different sequence. Every configuration input is sampled on the line-start strobe, so the host may change registers at any time during a line; the change applies to the next line only.

Top module: `hclk_rep_gen`

## Requirements
- R1: After reset, and before the first line-start strobe, the pixel counter is 0 and the window is empty. On the first sampled cycle `h1`=1, `h2`=0, `blank_active`=0, and on the next cycle `h1`=0, `h2`=1.
- R2: A 13-bit pixel counter reads 0 in the cycle after `line_start` is sampled high and then rises by one every clock. All pixel positions below refer to this counter.
- R3: `blank_active` is 1 exactly when `cfg_win_start` <= pixel < `cfg_win_end`.
- R4: Outside the window `h1` is 1 on even pixel positions and 0 on odd ones, and `h2` is always the inverse of `h1`.
- R5: Inside the window, slot k covers offsets k*`cfg_area_len` through k*`cfg_area_len`+`cfg_area_len`-1 from the window start. Slots with k >= `cfg_area_count` or k >= 6, and every slot when the length is 0, hold both outputs masked (`h1`=0, `h2`=1).
- R6: A burst with offset o and count n covers slot offsets o through o+2n-1. At an even distance from o, `h1` is 1 and `h2` is 0; at an odd distance, `h1` is 0 and `h2` is 1. Where bursts overlap, A wins over B, and B wins over C. Offsets are `cfg_ofs_a`, `cfg_ofs_b` and `cfg_ofs_c`.
- R7: A count of zero suppresses that burst for that area and output. With no burst covering a position, `h1` is 0 and `h2` is 1.
- R8: The 4-bit count for area a, output u (0=`h1`, 1=`h2`) and burst b (0=A, 1=B, 2=C) sits at `cfg_counts` bit ((a*2+u)*3+b)*4. `h1` and `h2` follow their own counts independently.
- R9: A burst that would extend past the last offset of its slot is cut at the slot boundary and does not continue into the next slot.
- R10: On even lines slot k uses area k. On odd lines slot k uses the area held in `cfg_odd_order` bits [3k+2:3k]. A value above 5 masks the slot.
- R11: All configuration inputs and the line parity are captured when `line_start` is sampled. Changes made later in the line do not affect the outputs until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe that begins a line |
| line_odd | input | 1 | Parity of the line that starts (1 = odd) |
| cfg_win_start | input | 13 | First pixel of the blanking window |
| cfg_win_end | input | 13 | First pixel after the blanking window |
| cfg_area_len | input | 13 | Slot length in pixels |
| cfg_area_count | input | 3 | Number of active slots |
| cfg_ofs_a | input | 13 | Burst A offset within a slot |
| cfg_ofs_b | input | 13 | Burst B offset within a slot |
| cfg_ofs_c | input | 13 | Burst C offset within a slot |
| cfg_counts | input | 144 | Packed pulse counts per area, output and burst |
| cfg_odd_order | input | 18 | Slot-to-area map used on odd lines |
| h1 | output | 1 | Horizontal clock 1 |
| h2 | output | 1 | Horizontal clock 2 |
| blank_active | output | 1 | High inside the blanking window |

## Verification
A slip in the pixel, slot-offset or slot counters moves every later pulse. It therefore shows up at the first burst edge after the fault, which is at most one slot length into the window; a wrong free-running phase shows on the very next cycle. A wrong slot-to-area map or count lookup changes the pulse count of a whole slot, and it is caught by comparing every pixel of even and odd lines against a model computed in the bench. Late capture of registers shows as a changed pulse pattern in the rest of the line in which the registers were written.

// File: rtl/hclk_pkg.sv
package hclk_pkg;
    localparam int HCLK_CNT_W  = 13;
    localparam int HCLK_AREAS  = 6;
    localparam int HCLK_BURSTS = 3;
    localparam int HCLK_REP_W  = 4;
    localparam int HCLK_OUTS   = 2;
endpackage

// File: rtl/hclk_slot_map.sv
module hclk_slot_map #(
    parameter int CNT_W   = 13,
    parameter int N_AREAS = 6,
    parameter int AREA_W  = 3
) (
    input  logic [CNT_W-1:0]          slot,
    input  logic                      odd,
    input  logic [AREA_W-1:0]         num,
    input  logic [N_AREAS*AREA_W-1:0] order,
    output logic                      ok,
    output logic [AREA_W-1:0]         area
);
    logic              slot_in;
    logic [AREA_W-1:0] sidx;
    logic [AREA_W-1:0] pick;

    always_comb begin
        slot_in = (slot < CNT_W'(N_AREAS)) && (slot < CNT_W'(num));
        sidx    = slot_in ? slot[AREA_W-1:0] : '0;
        pick    = odd ? order[sidx*AREA_W +: AREA_W] : sidx;
        ok      = slot_in && ({1'b0, pick} < (AREA_W+1)'(N_AREAS));
        area    = ok ? pick : '0;
    end
endmodule

// File: rtl/hclk_burst_lane.sv
module hclk_burst_lane #(
    parameter int CNT_W   = 13,
    parameter int REP_W   = 4,
    parameter int N_BURST = 3
) (
    input  logic                       valid,
    input  logic [CNT_W-1:0]           off,
    input  logic [N_BURST*CNT_W-1:0]   ofs,
    input  logic [N_BURST*REP_W-1:0]   cnt,
    output logic                       act,
    output logic                       ph
);
    logic [N_BURST-1:0] hit;
    logic [N_BURST-1:0] pol;

    for (genvar g = 0; g < N_BURST; g++) begin : g_burst
        logic [CNT_W-1:0] o_g;
        logic [CNT_W-1:0] rel_g;
        logic [REP_W-1:0] n_g;
        logic [REP_W:0]   span_g;
        assign o_g    = ofs[g*CNT_W +: CNT_W];
        assign n_g    = cnt[g*REP_W +: REP_W];
        assign span_g = {n_g, 1'b0};
        assign rel_g  = off - o_g;
        assign hit[g] = valid && (n_g != '0) && (off >= o_g)
                        && (rel_g < CNT_W'(span_g));
        assign pol[g] = ~rel_g[0];
    end

    // lowest burst index has priority
    always_comb begin
        act = 1'b0;
        ph  = 1'b0;
        for (int b = N_BURST - 1; b >= 0; b--) begin
            if (hit[b]) begin
                act = 1'b1;
                ph  = pol[b];
            end
        end
    end
endmodule

// File: rtl/hclk_rep_gen.sv
module hclk_rep_gen
    import hclk_pkg::*;
#(
    parameter int CNT_W   = HCLK_CNT_W,
    parameter int N_AREAS = HCLK_AREAS,
    parameter int REP_W   = HCLK_REP_W,
    parameter int AREA_W  = $clog2(HCLK_AREAS),
    localparam int N_BURST   = HCLK_BURSTS,
    localparam int N_OUT     = HCLK_OUTS,
    localparam int LANE_BITS = N_BURST * REP_W,
    localparam int REP_BITS  = N_AREAS * N_OUT * LANE_BITS,
    localparam int ALT_BITS  = N_AREAS * AREA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start,
    input  logic                line_odd,
    input  logic [CNT_W-1:0]    cfg_win_start,
    input  logic [CNT_W-1:0]    cfg_win_end,
    input  logic [CNT_W-1:0]    cfg_area_len,
    input  logic [AREA_W-1:0]   cfg_area_count,
    input  logic [CNT_W-1:0]    cfg_ofs_a,
    input  logic [CNT_W-1:0]    cfg_ofs_b,
    input  logic [CNT_W-1:0]    cfg_ofs_c,
    input  logic [REP_BITS-1:0] cfg_counts,
    input  logic [ALT_BITS-1:0] cfg_odd_order,
    output logic                h1,
    output logic                h2,
    output logic                blank_active
);
    typedef struct packed {
        logic [CNT_W-1:0]         pix;
        logic [CNT_W-1:0]         off;
        logic [CNT_W-1:0]         slot;
        logic                     odd;
        logic [CNT_W-1:0]         bs;
        logic [CNT_W-1:0]         be;
        logic [CNT_W-1:0]         len;
        logic [AREA_W-1:0]        num;
        logic [N_BURST*CNT_W-1:0] ofs;
        logic [REP_BITS-1:0]      rep;
        logic [ALT_BITS-1:0]      alt;
    } st_t;

    st_t s_d, s_q;

    logic              in_win;
    logic              area_ok;
    logic [AREA_W-1:0] area_idx;
    logic              lane_valid;
    logic [N_OUT-1:0]  lane_act;
    logic [N_OUT-1:0]  lane_ph;

    assign in_win = (s_q.pix >= s_q.bs) && (s_q.pix < s_q.be);

    hclk_slot_map #(
        .CNT_W(CNT_W), .N_AREAS(N_AREAS), .AREA_W(AREA_W)
    ) u_slot_map (
        .slot (s_q.slot),
        .odd  (s_q.odd),
        .num  (s_q.num),
        .order(s_q.alt),
        .ok   (area_ok),
        .area (area_idx)
    );

    assign lane_valid = in_win && (s_q.len != '0) && area_ok;

    for (genvar u = 0; u < N_OUT; u++) begin : g_out
        logic [LANE_BITS-1:0] cnt_u;
        assign cnt_u = s_q.rep[(int'(area_idx) * N_OUT + u) * LANE_BITS +: LANE_BITS];
        hclk_burst_lane #(
            .CNT_W(CNT_W), .REP_W(REP_W), .N_BURST(N_BURST)
        ) u_lane (
            .valid(lane_valid),
            .off  (s_q.off),
            .ofs  (s_q.ofs),
            .cnt  (cnt_u),
            .act  (lane_act[u]),
            .ph   (lane_ph[u])
        );
    end

    always_comb begin
        s_d = s_q;
        if (line_start) begin
            s_d.pix  = '0;
            s_d.off  = '0;
            s_d.slot = '0;
            s_d.odd  = line_odd;
            s_d.bs   = cfg_win_start;
            s_d.be   = cfg_win_end;
            s_d.len  = cfg_area_len;
            s_d.num  = cfg_area_count;
            s_d.ofs  = {cfg_ofs_c, cfg_ofs_b, cfg_ofs_a};
            s_d.rep  = cfg_counts;
            s_d.alt  = cfg_odd_order;
        end else begin
            s_d.pix = s_q.pix + 1'b1;
            if (in_win) begin
                if ((s_q.off + 1'b1) >= s_q.len) begin
                    s_d.off = '0;
                    if (s_q.slot != '1) begin
                        s_d.slot = s_q.slot + 1'b1;
                    end
                end else begin
                    s_d.off = s_q.off + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        blank_active = in_win;
        if (!in_win) begin
            h1 = ~s_q.pix[0];
            h2 = s_q.pix[0];
        end else begin
            h1 = lane_act[0] & lane_ph[0];
            h2 = ~(lane_act[1] & lane_ph[1]);
        end
    end
endmodule

// File: rtl/hclk_rep_gen_chk.sv
module hclk_rep_gen_chk #(
    parameter int CNT_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_start,
    input logic             h1,
    input logic             h2,
    input logic             blank_active,
    input logic [CNT_W-1:0] pix,
    input logic [CNT_W-1:0] win_start,
    input logic [CNT_W-1:0] win_end
);
    assert_pix_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (pix == '0));

    assert_pix_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> (pix == CNT_W'($past(pix) + 1'b1)));

    assert_free_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_active |-> (h2 == ~h1));

    assert_free_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_active && !line_start) |=> (blank_active || (h1 != $past(h1))));

    assert_window_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_active && !line_start) |=> (!blank_active || (pix == win_start)));

    assert_shadow_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> ($stable(win_start) && $stable(win_end)));
endmodule

bind hclk_rep_gen hclk_rep_gen_chk #(.CNT_W(CNT_W)) u_hclk_rep_gen_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .h1          (h1),
    .h2          (h2),
    .blank_active(blank_active),
    .pix         (s_q.pix),
    .win_start   (s_q.bs),
    .win_end     (s_q.be)
);

// File: tb/hclk_rep_gen_bench.sv
module hclk_rep_gen_bench;
    localparam int CLK_P = 10;
    localparam int CW    = 13;
    localparam int NA    = 6;
    localparam int RW    = 4;
    localparam int REPB  = NA * 2 * 3 * RW;
    localparam int ALTB  = NA * 3;
    localparam int LINE  = 48;

    typedef struct {
        logic [CW-1:0]   bs, be, len;
        logic [2:0]      num;
        logic [CW-1:0]   oa, ob, oc;
        logic [REPB-1:0] rep;
        logic [ALTB-1:0] alt;
    } cfg_t;

    // {odd, pixel, h1 h2 blank}, hand-computed for config c1
    localparam logic [16:0] SPOT [16] = '{
        {1'b0, 13'd4,  3'b100}, {1'b0, 13'd5,  3'b010},
        {1'b0, 13'd10, 3'b101}, {1'b0, 13'd11, 3'b011},
        {1'b0, 13'd16, 3'b101}, {1'b0, 13'd18, 3'b011},
        {1'b0, 13'd22, 3'b111}, {1'b0, 13'd30, 3'b101},
        {1'b0, 13'd34, 3'b011}, {1'b0, 13'd39, 3'b011},
        {1'b0, 13'd40, 3'b100}, {1'b1, 13'd10, 3'b111},
        {1'b1, 13'd12, 3'b111}, {1'b1, 13'd18, 3'b101},
        {1'b1, 13'd22, 3'b101}, {1'b1, 13'd26, 3'b101}
    };

    logic clk, rst_n, line_start, line_odd, h1, h2, blank_active;
    cfg_t drv, lcfg, c1, c2;
    int   checks, errors;

    hclk_rep_gen u_hclk_rep_gen (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_odd(line_odd),
        .cfg_win_start(drv.bs), .cfg_win_end(drv.be), .cfg_area_len(drv.len),
        .cfg_area_count(drv.num), .cfg_ofs_a(drv.oa), .cfg_ofs_b(drv.ob),
        .cfg_ofs_c(drv.oc), .cfg_counts(drv.rep), .cfg_odd_order(drv.alt),
        .h1(h1), .h2(h2), .blank_active(blank_active)
    );

    initial clk = 1'b0;
    always #(CLK_P / 2) clk = ~clk;

    function automatic cfg_t set_rep(cfg_t c, int a, int u, int b, int v);
        c.rep[((a * 2 + u) * 3 + b) * RW +: RW] = v[RW-1:0];
        return c;
    endfunction

    function automatic logic [2:0] ref_px(cfg_t c, bit odd, int p);
        int bs, be, len, rel, slot, off, area, n, d;
        int ofs [3];
        bit hh1, hh2, done;
        bs = int'(c.bs); be = int'(c.be); len = int'(c.len);
        ofs[0] = int'(c.oa); ofs[1] = int'(c.ob); ofs[2] = int'(c.oc);
        if (!(p >= bs && p < be)) begin
            hh1 = (p % 2 == 0);
            return {hh1, !hh1, 1'b0};
        end
        hh1 = 1'b0; hh2 = 1'b1;
        if (len == 0) return {hh1, hh2, 1'b1};
        rel = p - bs; slot = rel / len; off = rel % len;
        if (slot >= int'(c.num) || slot >= NA) return {hh1, hh2, 1'b1};
        area = odd ? int'(c.alt[slot * 3 +: 3]) : slot;
        if (area >= NA) return {hh1, hh2, 1'b1};
        for (int u = 0; u < 2; u++) begin
            done = 1'b0;
            for (int b = 0; b < 3; b++) begin
                n = int'(c.rep[((area * 2 + u) * 3 + b) * RW +: RW]);
                d = off - ofs[b];
                if (!done && n != 0 && d >= 0 && d < 2 * n) begin
                    done = 1'b1;
                    if (u == 0) hh1 = (d % 2 == 0);
                    else        hh2 = (d % 2 != 0);
                end
            end
        end
        return {hh1, hh2, 1'b1};
    endfunction

    task automatic chk(string req, int p, logic [2:0] got, logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s pixel %0d h1h2blk got %b expected %b", req, p, got, exp);
        end
    endtask

    task automatic start_line(bit odd);
        @(negedge clk);
        line_start = 1'b1;
        line_odd   = odd;
        lcfg       = drv;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic run_line(bit odd, string req, bit swap);
        start_line(odd);
        for (int p = 0; p < LINE; p++) begin
            chk(req, p, {h1, h2, blank_active}, ref_px(lcfg, odd, p));
            if (swap && p == 20) drv = c2;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        checks = 0; errors = 0;
        rst_n = 1'b0; line_start = 1'b0; line_odd = 1'b0;

        c1 = '{bs: 13'd10, be: 13'd40, len: 13'd12, num: 3'd2,
               oa: 13'd0, ob: 13'd4, oc: 13'd8, rep: '0, alt: '0};
        c1 = set_rep(c1, 0, 0, 0, 1); c1 = set_rep(c1, 0, 0, 1, 2);
        c1 = set_rep(c1, 0, 1, 0, 1); c1 = set_rep(c1, 0, 1, 1, 2);
        c1 = set_rep(c1, 1, 0, 0, 2); c1 = set_rep(c1, 1, 0, 2, 1);
        c1 = set_rep(c1, 1, 1, 2, 1);
        c1.alt[2:0] = 3'd1; c1.alt[5:3] = 3'd0;

        c2 = '{bs: 13'd3, be: 13'd33, len: 13'd6, num: 3'd7,
               oa: 13'd0, ob: 13'd2, oc: 13'd4, rep: '0, alt: '0};
        for (int a = 0; a < NA; a++) begin
            c2 = set_rep(c2, a, 0, 0, 1); c2 = set_rep(c2, a, 0, 2, 3);
            c2 = set_rep(c2, a, 1, 1, 2); c2 = set_rep(c2, a, 1, 2, 1);
        end
        c2.alt = {3'd1, 3'd2, 3'd3, 3'd0, 3'd7, 3'd5};

        drv = c1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and free-running start
        chk("R1", 0, {h1, h2, blank_active}, 3'b100);
        @(negedge clk);
        chk("R1", 1, {h1, h2, blank_active}, 3'b010);

        // R3 R4 R5 R6 R7 R8 R10: hand-computed spot vectors
        for (int i = 0; i < 16; i++) begin
            start_line(SPOT[i][16]);
            repeat (int'(SPOT[i][15:3])) @(negedge clk);
            chk("R3 R4 R5 R6 R7 R8 R10", int'(SPOT[i][15:3]),
                {h1, h2, blank_active}, SPOT[i][2:0]);
        end

        // R2 R6: whole even and odd lines against the model
        run_line(1'b0, "R2 R6", 1'b0);
        run_line(1'b1, "R10", 1'b0);
        // R9: cut bursts, priority overlap, invalid odd map entry
        drv = c2;
        run_line(1'b0, "R9 R5", 1'b0);
        run_line(1'b1, "R9 R10", 1'b0);
        // R11: mid-line writes wait for the next strobe
        drv = c1;
        run_line(1'b0, "R11", 1'b1);
        run_line(1'b1, "R11", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule